// File: doc/BRIEF.md
# Serial-Loaded Converter Code Register

This block is the digital front end of a 16-bit serial-input converter. A host sends a word over three wires: an active-low frame select, a serial clock and a data line. The block oversamples these pins in the system clock domain, shifts the data in on each serial clock rising edge, and counts the bits. When the frame select returns high after exactly the configured number of bits, the word moves into a parallel code latch. The latch drives the converter code output, and a one-cycle update strobe marks each load.

Frames that are too short or too long leave the latch untouched and raise a one-cycle frame error pulse. An active-low clear input forces the latch to a reset code at once, without waiting for a clock and whatever the serial path is doing. System reset forces the same code. A parameter chooses that code: all zeros for a unipolar output, or the top bit alone (0x8000, midscale) for an offset-binary bipolar output.

Top module: `dac_serial_front`

## Requirements
- R1: While reset is asserted, and after it is released, `code_q` equals the reset code until a valid frame loads, and neither strobe fires.
- R2: `din` is captured on each rising edge of `sclk` while `cs_n` is low. The first bit sent becomes bit 15 of the code and the last becomes bit 0.
- R3: The latch keeps its old value while the frame is still open, including after the 16th bit. It changes only after `cs_n` rises.
- R4: Each valid frame produces exactly one `update_p` pulse, one system clock wide, in the cycle the new code appears.
- R5: A frame with fewer than 16 bits, including a frame with no bits, leaves `code_q` unchanged. It gives one `frame_err_p` pulse and no `update_p`.
- R6: A frame with more than 16 bits leaves `code_q` unchanged and gives one `frame_err_p` pulse.
- R7: `sclk` edges while `cs_n` is high shift nothing and change no output. Every frame starts counting bits afresh at the falling edge of `cs_n`.
- R8: `clr_n` low forces `code_q` to the reset code with no clock edge needed. The reset code is 0x8000 when BIPOLAR=1 and 0x0000 when BIPOLAR=0.
- R9: A frame that closes while `clr_n` is low does not change `code_q` and gives no `update_p`. The code stays at the reset code after `clr_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs_n | input | 1 | Frame select, active low, asynchronous to `clk` |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| din | input | 1 | Serial data, MSB first |
| clr_n | input | 1 | Asynchronous active-low clear to the reset code |
| code_q | output | DATA_W | Latched converter code |
| update_p | output | 1 | One-cycle pulse when `code_q` takes a new word |
| frame_err_p | output | 1 | One-cycle pulse when a frame closes with the wrong bit count |

## Verification
The bench builds two copies side by side from the same serial pins. `dut` uses BIPOLAR=1 and `dut_uni` uses BIPOLAR=0, with DATA_W=16 and two synchronizer stages. Because the two reset codes differ, every clear and reset check tells the midscale code apart from zero, and a wrong parameter decode shows up in one of the two copies. The serial clock runs at one eighth of the system clock, so both bit-count boundaries (15 and 17 bits) are checked, and so are clears that arrive between clock edges.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;

  // Synchronized serial pins, bundled so they cross the clock boundary together.
  typedef struct packed {
    logic din;
    logic sclk;
    logic cs_n;
  } ser_pins_t;

  localparam int SER_PINS_W = $bits(ser_pins_t);

  // Pin levels with no host activity: frame select deasserted, clock low.
  localparam ser_pins_t PINS_IDLE = '{din: 1'b0, sclk: 1'b0, cs_n: 1'b1};

endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
  parameter int               WIDTH  = 3,
  parameter int               STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= IDLE;
        else        stg_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= IDLE;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
  import dac_if_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ser_pins_t         pins,
  output logic [DATA_W-1:0] word_q,
  output logic              load_p,
  output logic              err_p
);
  localparam int              CNT_W   = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(DATA_W);

  logic              cs_prev_q, sclk_prev_q;
  logic [DATA_W-1:0] word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              load_d, err_d;
  logic              cs_fall, cs_rise, sclk_rise;

  always_comb begin
    cs_fall   = cs_prev_q & ~pins.cs_n;
    cs_rise   = ~cs_prev_q & pins.cs_n;
    sclk_rise = ~sclk_prev_q & pins.sclk;
    word_d    = word_q;
    cnt_d     = cnt_q;
    load_d    = 1'b0;
    err_d     = 1'b0;
    if (cs_fall) begin
      cnt_d = '0;
    end else if (!pins.cs_n && sclk_rise) begin
      word_d = {word_q[DATA_W-2:0], pins.din};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;   // saturate: any overrun is an error
    end
    if (cs_rise) begin
      if (cnt_q == CNT_OK) load_d = 1'b1;
      else                 err_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
      word_q      <= '0;
      cnt_q       <= '0;
      load_p      <= 1'b0;
      err_p       <= 1'b0;
    end else begin
      cs_prev_q   <= pins.cs_n;
      sclk_prev_q <= pins.sclk;
      word_q      <= word_d;
      cnt_q       <= cnt_d;
      load_p      <= load_d;
      err_p       <= err_d;
    end
  end
endmodule

// File: rtl/dac_code_latch.sv
module dac_code_latch #(
  parameter int                DATA_W     = 16,
  parameter logic [DATA_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] code_q,
  output logic              upd_p
);
  logic upd_d;

  always_comb upd_d = load_en & clr_n;

  // Clear acts without a clock and has priority over any load.
  always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
    if (!rst_n)       code_q <= RESET_CODE;
    else if (!clr_n)  code_q <= RESET_CODE;
    else if (load_en) code_q <= word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_p <= 1'b0;
    else        upd_p <= upd_d;
  end
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dac_if_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter bit BIPOLAR     = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              clr_n,
  output logic [DATA_W-1:0] code_q,
  output logic              update_p,
  output logic              frame_err_p
);
  localparam logic [DATA_W-1:0] RESET_CODE =
    BIPOLAR ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

  logic              rst_n_i;
  ser_pins_t         pins_raw, pins_s;
  logic [DATA_W-1:0] word;
  logic              load_p;

  assign pins_raw = '{din: din, sclk: sclk, cs_n: cs_n};

  dac_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  dac_in_sync #(.WIDTH(SER_PINS_W), .STAGES(SYNC_STAGES), .IDLE(PINS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .d(pins_raw), .q(pins_s)
  );

  dac_frame_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n_i), .pins(pins_s),
    .word_q(word), .load_p(load_p), .err_p(frame_err_p)
  );

  dac_code_latch #(.DATA_W(DATA_W), .RESET_CODE(RESET_CODE)) u_latch (
    .clk(clk), .rst_n(rst_n_i), .clr_n(clr_n), .load_en(load_p),
    .word(word), .code_q(code_q), .upd_p(update_p)
  );
endmodule

// File: rtl/dac_serial_front_chk.sv
module dac_serial_front_chk #(
  parameter int                DATA_W     = 16,
  parameter logic [DATA_W-1:0] RESET_CODE = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic [DATA_W-1:0] code_q,
  input logic              update_p,
  input logic              frame_err_p
);
  AST_UPDATE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    update_p |=> !update_p); // R4

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_p |=> !frame_err_p); // R5

  AST_ERR_EXCLUDES_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(update_p && frame_err_p)); // R6

  AST_CODE_HOLDS_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!update_p && clr_n && $past(clr_n)) |-> $stable(code_q)); // R3

  AST_CLEAR_GIVES_RESET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (code_q == RESET_CODE)); // R8

  AST_NO_UPDATE_UNDER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    update_p |-> $past(clr_n)); // R9
endmodule

bind dac_serial_front dac_serial_front_chk #(.DATA_W(DATA_W), .RESET_CODE(RESET_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .code_q(code_q),
  .update_p(update_p), .frame_err_p(frame_err_p)
);

// File: tb/tb_dac_serial_front.sv
`timescale 1ns/1ps
module tb_dac_serial_front;
  localparam int W = 16;
  localparam logic [W-1:0] MID = 16'h8000;
  localparam int NVEC = 6;
  localparam logic [W-1:0] VEC [NVEC] = '{16'hA5C3, 16'h0001, 16'hFFFF, 16'h8000, 16'h0000, 16'h7FFE};

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, din, clr_n;
  logic [W-1:0] code_b, code_u;
  logic upd_b, upd_u, err_b, err_u;

  int total = 0, bad = 0;
  int n_upd_b = 0, n_upd_u = 0, n_err_b = 0, n_err_u = 0, n_wide = 0;
  logic upd_b_prev = 1'b0;

  always #10 clk = ~clk;

  dac_serial_front #(.DATA_W(W), .BIPOLAR(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .clr_n(clr_n),
    .code_q(code_b), .update_p(upd_b), .frame_err_p(err_b));

  dac_serial_front #(.DATA_W(W), .BIPOLAR(1'b0)) dut_uni (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .clr_n(clr_n),
    .code_q(code_u), .update_p(upd_u), .frame_err_p(err_u));

  always @(posedge clk) begin
    if (upd_b) n_upd_b++;
    if (upd_u) n_upd_u++;
    if (err_b) n_err_b++;
    if (err_u) n_err_u++;
    if (upd_b && upd_b_prev) n_wide++;
    upd_b_prev <= upd_b;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame();
    cs_n = 1'b0; wait_clk(4);
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      din = w[i]; wait_clk(4);
      sclk = 1'b1; wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
  endtask

  task automatic close_frame();
    cs_n = 1'b1; wait_clk(10);
  endtask

  task automatic send(input logic [31:0] w, input int n);
    open_frame(); shift_bits(w, n); close_frame();
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int ub, uu, eb, eu;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; clr_n = 1'b1;
    wait_clk(3);
    chk("R1 reset code bipolar", code_b, MID);
    chk("R1 reset code unipolar", code_u, 0);
    rst_n = 1'b1; wait_clk(6);
    chk("R1 code after release", {code_b, code_u}, {MID, 16'h0000});
    chk("R1 no strobes", n_upd_b + n_err_b + n_upd_u + n_err_u, 0);

    // Vector table: each word loads both copies (R2, R4).
    for (int v = 0; v < NVEC; v++) begin
      ub = n_upd_b; uu = n_upd_u; eb = n_err_b;
      send(VEC[v], W);
      chk("R2 bipolar load", code_b, VEC[v]);
      chk("R2 unipolar load", code_u, VEC[v]);
      chk("R4 one update pulse", (n_upd_b - ub) + 16 * (n_upd_u - uu), 17);
      chk("R4 no error on valid", n_err_b - eb, 0);
    end

    // R3: no change before the frame closes.
    open_frame(); shift_bits(32'h1234, W); wait_clk(10);
    chk("R3 held while frame open", code_b, VEC[NVEC-1]);
    close_frame();
    chk("R3 loaded at close", code_b, 16'h1234);

    // R5: short frames.
    ub = n_upd_b; eb = n_err_b;
    send(32'h0F0F, W - 1);
    chk("R5 short frame keeps code", code_b, 16'h1234);
    chk("R5 short frame error pulse", n_err_b - eb, 1);
    chk("R5 short frame no update", n_upd_b - ub, 0);
    eb = n_err_b;
    send(32'h0, 0);
    chk("R5 empty frame error pulse", {n_err_b - eb, code_u}, {32'd1, 16'h1234});

    // R6: long frame.
    ub = n_upd_b; eb = n_err_b;
    send(32'h1BEEF, W + 1);
    chk("R6 long frame keeps code", code_b, 16'h1234);
    chk("R6 long frame error pulse", (n_err_b - eb) + 16 * (n_upd_b - ub), 1);

    // R7: clocks while deselected are ignored.
    ub = n_upd_b; eb = n_err_b;
    shift_bits(32'hFFFFF, 20);
    chk("R7 idle clocks no change", code_b, 16'h1234);
    chk("R7 idle clocks no strobes", (n_upd_b - ub) + (n_err_b - eb), 0);
    send(32'hBEEF, W);
    chk("R7 next frame counts afresh", code_b, 16'hBEEF);

    // R8: asynchronous clear, checked before any clock edge.
    @(negedge clk); #1 clr_n = 1'b0; #3;
    chk("R8 clear bipolar no clock", code_b, MID);
    chk("R8 clear unipolar no clock", code_u, 0);
    wait_clk(3); clr_n = 1'b1; wait_clk(3);

    // R9: frame closing during clear.
    send(32'h5555, W);
    chk("R9 setup load", code_b, 16'h5555);
    clr_n = 1'b0; ub = n_upd_b; eb = n_err_b;
    send(32'h3C3C, W);
    chk("R9 code held at reset under clear", code_b, MID);
    chk("R9 no update under clear", (n_upd_b - ub) + (n_err_b - eb), 0);
    clr_n = 1'b1; wait_clk(10);
    chk("R9 stays reset after release", {code_b, code_u}, {MID, 16'h0000});

    chk("R4 pulses one cycle wide", n_wide, 0);

    // R1: reset in mid-run.
    send(32'h6789, W);
    @(negedge clk); rst_n = 1'b0; #2;
    chk("R1 mid-run reset", {code_b, code_u}, {MID, 16'h0000});
    wait_clk(2); rst_n = 1'b1; wait_clk(5);

    finish_run();
  end
endmodule